// File: doc/BRIEF.md
# Flash Block Write-Protection Manager

This block keeps a write-protection state for every erase block of a flash array. A block can be open for writing, locked, or tightly locked. A tight lock is sticky: plain lock and unlock commands cannot remove it, and only a reset clears it. Software first loads a first-block and a last-block register. It then issues one of four commands: open a range, lock a range, tighten a range, or open the whole array. The block carries out the command by walking the selected blocks in ascending order, one block per clock.

A query port answers, in the same cycle, whether a given block may be programmed or erased. The program and erase engines of the flash controller use this port. A status register holds the state most recently written by a walk. A busy level covers each walk, and a done pulse ends it. A command-error pulse reports a walk that ran past the last block of the array.

Top module: `blk_lock_mgr`

## Requirements
- R1: After reset every block is locked, the protection status reads 3'b010, busy is low, and the first-block and last-block registers read 0.
- R2: States are one-hot: tight = 3'b001, locked = 3'b010, open = 3'b100. The protection status always holds exactly one of these codes.
- R3: A write to the first-block register keeps the low ADDR_W bits of the data and copies that value into the last-block register. A write to the last-block register changes only the last-block register.
- R4: Opcode 0x23 opens the blocks from the first block to the last block, inclusive, in ascending order, one block per clock. Busy is high from the cycle after acceptance until the walk ends. Busy falls in the same cycle as a one-cycle done pulse, and busy lasts one cycle more than the number of blocks visited.
- R5: Opcode 0x2A locks the blocks from the first block to the last block, inclusive.
- R6: An open, lock or open-all walk stops at the first tight block it reaches and leaves that block unchanged. Every later block in the range is also left unchanged.
- R7: Opcode 0x2C makes every block in the range tight, except open blocks. The walk skips open blocks and continues past them.
- R8: Opcode 0x27 opens blocks 0 through NUM_BLOCKS-1, subject to the stop rule in R6.
- R9: Each block written by a walk also loads its new state into the protection status. A walk that writes nothing leaves the status unchanged.
- R10: When a walk reaches an index at or above NUM_BLOCKS, it stops. A one-cycle command-error pulse is issued together with done.
- R11: A command presented while busy is ignored, and so is any opcode other than the four above. Neither starts a walk or changes any block.
- R12: The query output is 1 only for a block in the open state. Tight and locked blocks return 0.
- R13: If the first block is above the last block, a range command writes no block. The walk ends after one busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous cold reset |
| start_we | input | 1 | Write strobe for the first-block register |
| end_we | input | 1 | Write strobe for the last-block register |
| addr_wdata | input | REG_W | Data for the range register writes |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 8 | Command opcode |
| query_blk | input | ADDR_W | Block index to query |
| query_writable | output | 1 | The queried block is open |
| start_addr | output | ADDR_W | First-block register |
| end_addr | output | ADDR_W | Last-block register |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| cmd_err | output | 1 | One-cycle pulse when a walk passes the array end |
| prot_status | output | 3 | State written most recently by a walk |

## Verification
The bench builds the block with NUM_BLOCKS = 12. The range registers are then 4 bits wide, so they can hold indices 12 to 15, which lie beyond the array. This is the only way a walk can reach the out-of-range stop and raise the command-error pulse. A power-of-two count would make that path unreachable. The open-all walk still ends cleanly at index 11, which shows that the array end on its own does not raise an error.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

    typedef enum logic [2:0] {
        LS_TIGHT  = 3'b001,
        LS_LOCKED = 3'b010,
        LS_OPEN   = 3'b100
    } lock_state_e;

    typedef enum logic [1:0] {
        WK_OPEN,
        WK_LOCK,
        WK_TIGHT
    } walk_kind_e;

    localparam logic [7:0] OP_OPEN_RANGE  = 8'h23;
    localparam logic [7:0] OP_OPEN_ALL    = 8'h27;
    localparam logic [7:0] OP_LOCK_RANGE  = 8'h2A;
    localparam logic [7:0] OP_TIGHT_RANGE = 8'h2C;

endpackage

// File: rtl/blk_lock_range.sv
module blk_lock_range #(
    parameter int REG_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_we,
    input  logic              end_we,
    input  logic [REG_W-1:0]  wdata,
    output logic [ADDR_W-1:0] first_blk,
    output logic [ADDR_W-1:0] last_blk
);

    typedef struct packed {
        logic [ADDR_W-1:0] first;
        logic [ADDR_W-1:0] last;
    } range_t;

    range_t rng_d, rng_q;

    always_comb begin
        rng_d = rng_q;
        if (start_we) begin
            rng_d.first = wdata[ADDR_W-1:0];
            rng_d.last  = wdata[ADDR_W-1:0];
        end
        if (end_we) begin
            rng_d.last = wdata[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rng_q <= '0;
        end else begin
            rng_q <= rng_d;
        end
    end

    assign first_blk = rng_q.first;
    assign last_blk  = rng_q.last;

    // R3: a lone first-block write leaves both registers equal
    assert_end_follows_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_we && !end_we) |=> (last_blk == first_blk));

endmodule

// File: rtl/blk_lock_array.sv
module blk_lock_array
    import blk_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 16,
    parameter int ADDR_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_idx,
    input  lock_state_e       wr_state,
    input  logic [ADDR_W-1:0] rd_idx,
    output lock_state_e       rd_state,
    input  logic [ADDR_W-1:0] q_idx,
    output logic              q_writable
);

    lock_state_e st_d [NUM_BLOCKS];
    lock_state_e st_q [NUM_BLOCKS];

    always_comb begin
        st_d = st_q;
        if (wr_en && (int'(wr_idx) < NUM_BLOCKS)) begin
            st_d[wr_idx] = wr_state;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BLOCKS; i++) begin
                st_q[i] <= LS_LOCKED;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_state   = (int'(rd_idx) < NUM_BLOCKS) ? st_q[rd_idx] : LS_LOCKED;
    assign q_writable = (int'(q_idx) < NUM_BLOCKS) && (st_q[q_idx] == LS_OPEN);

    // R6: the walker never overwrites a tight block with another state
    assert_tight_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_idx) < NUM_BLOCKS) && (st_q[wr_idx] == LS_TIGHT))
            |-> (wr_state == LS_TIGHT));

endmodule

// File: rtl/blk_lock_walker.sv
module blk_lock_walker
    import blk_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 16,
    parameter int ADDR_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [ADDR_W-1:0] first_blk,
    input  logic [ADDR_W-1:0] last_blk,
    output logic [ADDR_W-1:0] rd_idx,
    input  lock_state_e       rd_state,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_idx,
    output lock_state_e       wr_state,
    output logic              busy,
    output logic              done,
    output logic              cmd_err,
    output logic [2:0]        prot_status
);

    localparam int IDX_W = ADDR_W + 1;
    localparam logic [IDX_W-1:0] NUM_V  = IDX_W'(NUM_BLOCKS);
    localparam logic [IDX_W-1:0] ONE_V  = IDX_W'(1);

    typedef struct packed {
        logic             busy;
        walk_kind_e       kind;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last;
        logic             done;
        logic             err;
        lock_state_e      prot;
    } walk_t;

    walk_t w_d, w_q;
    logic  op_known;

    always_comb begin
        op_known = (cmd_op == OP_OPEN_RANGE) || (cmd_op == OP_OPEN_ALL) ||
                   (cmd_op == OP_LOCK_RANGE) || (cmd_op == OP_TIGHT_RANGE);
    end

    always_comb begin
        w_d      = w_q;
        w_d.done = 1'b0;
        w_d.err  = 1'b0;
        wr_en    = 1'b0;
        wr_state = LS_LOCKED;
        if (!w_q.busy) begin
            if (cmd_valid && op_known) begin
                w_d.busy = 1'b1;
                w_d.idx  = {1'b0, first_blk};
                w_d.last = {1'b0, last_blk};
                case (cmd_op)
                    OP_OPEN_ALL: begin
                        w_d.kind = WK_OPEN;
                        w_d.idx  = '0;
                        w_d.last = NUM_V - ONE_V;
                    end
                    OP_LOCK_RANGE:  w_d.kind = WK_LOCK;
                    OP_TIGHT_RANGE: w_d.kind = WK_TIGHT;
                    default:        w_d.kind = WK_OPEN;
                endcase
            end
        end else if (w_q.idx > w_q.last) begin
            w_d.busy = 1'b0;
            w_d.done = 1'b1;
        end else if (w_q.idx >= NUM_V) begin
            w_d.busy = 1'b0;
            w_d.done = 1'b1;
            w_d.err  = 1'b1;
        end else if (w_q.kind == WK_TIGHT) begin
            if (rd_state != LS_OPEN) begin
                wr_en    = 1'b1;
                wr_state = LS_TIGHT;
                w_d.prot = LS_TIGHT;
            end
            w_d.idx = w_q.idx + ONE_V;
        end else if (rd_state == LS_TIGHT) begin
            w_d.busy = 1'b0;
            w_d.done = 1'b1;
        end else begin
            wr_en    = 1'b1;
            wr_state = (w_q.kind == WK_LOCK) ? LS_LOCKED : LS_OPEN;
            w_d.prot = wr_state;
            w_d.idx  = w_q.idx + ONE_V;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q      <= '0;
            w_q.kind <= WK_OPEN;
            w_q.prot <= LS_LOCKED;
        end else begin
            w_q <= w_d;
        end
    end

    assign rd_idx      = w_q.idx[ADDR_W-1:0];
    assign wr_idx      = w_q.idx[ADDR_W-1:0];
    assign busy        = w_q.busy;
    assign done        = w_q.done;
    assign cmd_err     = w_q.err;
    assign prot_status = w_q.prot;

    // R4: an idle walker starts a walk on a known opcode
    assert_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && op_known) |=> busy);

    // R4: busy never drops without a done pulse
    assert_busy_ends_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    // R10: an in-range walk index past the array end raises the error
    assert_overrun_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (w_q.idx <= w_q.last) && (w_q.idx >= NUM_V)) |=> cmd_err);

    // R2: the status is always a single one-hot code
    assert_status_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(prot_status) == 1);

endmodule

// File: rtl/blk_lock_mgr.sv
module blk_lock_mgr
    import blk_lock_pkg::*;
#(
    parameter int  NUM_BLOCKS = 16,
    parameter int  REG_W      = 16,
    localparam int ADDR_W     = $clog2(NUM_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_we,
    input  logic              end_we,
    input  logic [REG_W-1:0]  addr_wdata,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [ADDR_W-1:0] query_blk,
    output logic              query_writable,
    output logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] end_addr,
    output logic              busy,
    output logic              done,
    output logic              cmd_err,
    output logic [2:0]        prot_status
);

    logic [ADDR_W-1:0] rd_idx;
    logic [ADDR_W-1:0] wr_idx;
    logic              wr_en;
    lock_state_e       rd_state;
    lock_state_e       wr_state;

    blk_lock_range #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_range (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_we  (start_we),
        .end_we    (end_we),
        .wdata     (addr_wdata),
        .first_blk (start_addr),
        .last_blk  (end_addr)
    );

    blk_lock_walker #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) u_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .first_blk   (start_addr),
        .last_blk    (end_addr),
        .rd_idx      (rd_idx),
        .rd_state    (rd_state),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_state    (wr_state),
        .busy        (busy),
        .done        (done),
        .cmd_err     (cmd_err),
        .prot_status (prot_status)
    );

    blk_lock_array #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_state   (wr_state),
        .rd_idx     (rd_idx),
        .rd_state   (rd_state),
        .q_idx      (query_blk),
        .q_writable (query_writable)
    );

endmodule

// File: tb/blk_lock_mgr_tb.sv
module blk_lock_mgr_tb;

    localparam int NB = 12;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_we = 1'b0;
    logic          end_we = 1'b0;
    logic [15:0]   addr_wdata = '0;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_op = '0;
    logic [AW-1:0] query_blk = '0;
    logic          query_writable;
    logic [AW-1:0] start_addr;
    logic [AW-1:0] end_addr;
    logic          busy;
    logic          done;
    logic          cmd_err;
    logic [2:0]    prot_status;

    int checks = 0;
    int errors = 0;

    blk_lock_mgr #(.NUM_BLOCKS(NB), .REG_W(16)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_we       (start_we),
        .end_we         (end_we),
        .addr_wdata     (addr_wdata),
        .cmd_valid      (cmd_valid),
        .cmd_op         (cmd_op),
        .query_blk      (query_blk),
        .query_writable (query_writable),
        .start_addr     (start_addr),
        .end_addr       (end_addr),
        .busy           (busy),
        .done           (done),
        .cmd_err        (cmd_err),
        .prot_status    (prot_status)
    );

    always #5 clk = ~clk;

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end (actual hung, expected finish)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_start(input int v);
        start_we = 1'b1; addr_wdata = 16'(v);
        @(negedge clk);
        start_we = 1'b0;
    endtask

    task automatic wr_end(input int v);
        end_we = 1'b1; addr_wdata = 16'(v);
        @(negedge clk);
        end_we = 1'b0;
    endtask

    task automatic read_map(output logic [NB-1:0] m);
        for (int b = 0; b < NB; b++) begin
            query_blk = AW'(b);
            #1;
            m[b] = query_writable;
        end
    endtask

    task automatic run_cmd(input logic [7:0] op, output int busy_n, output bit err_seen,
                           output bit done_seen);
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        busy_n = 0; err_seen = 1'b0; done_seen = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (done) begin
                done_seen = 1'b1;
                err_seen = cmd_err;
                break;
            end
            if (busy) busy_n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [NB-1:0] m;
        do_reset();
        read_map(m);
        check(m == '0, "R1 all blocks locked after reset (R12 query)", int'(m), 0);
        check(prot_status == 3'b010, "R1 status reset value", prot_status, 2);
        check(!busy && !done && !cmd_err, "R1 idle after reset", {busy, done, cmd_err}, 0);
        check(start_addr == 0 && end_addr == 0, "R1 range regs reset", {start_addr, end_addr}, 0);
    endtask

    task automatic t_range_regs();
        wr_start(16'h13);
        check(start_addr == 3, "R3 first-block masked", start_addr, 3);
        check(end_addr == 3, "R3 last-block copied", end_addr, 3);
        wr_end(7);
        check(start_addr == 3 && end_addr == 7, "R3 last-block write alone",
              {start_addr, end_addr}, {4'd3, 4'd7});
    endtask

    task automatic t_open_range();
        int n; bit e, d; logic [NB-1:0] m;
        run_cmd(8'h23, n, e, d);
        check(d && !e, "R4 open range ends with done", {d, e}, 2);
        check(n == 6, "R4 busy cycles for five blocks", n, 6);
        read_map(m);
        check(m == 12'h0F8, "R4 blocks 3..7 open", int'(m), 12'h0F8);
        check(prot_status == 3'b100, "R9 status holds open code", prot_status, 4);
    endtask

    task automatic t_lock_range();
        int n; bit e, d; logic [NB-1:0] m;
        wr_start(5); wr_end(6);
        run_cmd(8'h2A, n, e, d);
        read_map(m);
        check(m == 12'h098, "R5 blocks 5,6 locked", int'(m), 12'h098);
        check(prot_status == 3'b010, "R9 status holds locked code", prot_status, 2);
    endtask

    task automatic t_tight_range();
        int n; bit e, d; logic [NB-1:0] m;
        wr_start(2); wr_end(8);
        run_cmd(8'h2C, n, e, d);
        check(n == 8, "R7 tight walk continues past open blocks", n, 8);
        read_map(m);
        check(m == 12'h098, "R7 open blocks skipped", int'(m), 12'h098);
        check(prot_status == 3'b001, "R2 status holds tight code", prot_status, 1);
    endtask

    task automatic t_stop_on_tight();
        int n; bit e, d; logic [NB-1:0] m;
        wr_start(0); wr_end(4);
        run_cmd(8'h23, n, e, d);
        check(n == 3 && d, "R6 open walk stops at tight block 2", n, 3);
        read_map(m);
        check(m == 12'h09B, "R6 blocks 0,1 opened, 2 kept", int'(m), 12'h09B);
        wr_start(2);
        run_cmd(8'h2A, n, e, d);
        check(n == 1, "R6 lock on tight block stops at once", n, 1);
        check(prot_status == 3'b100, "R9 no write keeps status", prot_status, 4);
        read_map(m);
        check(m == 12'h09B, "R6 tight block 2 unchanged", int'(m), 12'h09B);
    endtask

    task automatic t_open_all();
        int n; bit e, d; logic [NB-1:0] m;
        do_reset();
        run_cmd(8'h27, n, e, d);
        check(n == 13 && d && !e, "R8 open-all walks every block", n, 13);
        read_map(m);
        check(m == 12'hFFF, "R8 all blocks open", int'(m), 12'hFFF);
    endtask

    task automatic t_overrun();
        int n; bit e, d; logic [NB-1:0] m;
        wr_start(10); wr_end(14);
        check(end_addr == 14, "R3 last-block beyond array", end_addr, 14);
        run_cmd(8'h2A, n, e, d);
        check(d && e, "R10 error pulse with done", {d, e}, 3);
        check(n == 3, "R10 walk stops at index 12", n, 3);
        read_map(m);
        check(m == 12'h3FF, "R10 blocks 10,11 locked", int'(m), 12'h3FF);
        @(negedge clk);
        check(!cmd_err && !done, "R10 error is one cycle", {cmd_err, done}, 0);
    endtask

    task automatic t_ignore();
        int n; bit e, d; logic [NB-1:0] m;
        wr_start(0); wr_end(1);
        cmd_valid = 1'b1; cmd_op = 8'h2A;
        @(negedge clk);
        cmd_op = 8'h27;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < 20 && !done; i++) @(negedge clk);
        @(negedge clk);
        check(!busy, "R11 no second walk after busy command", busy, 0);
        read_map(m);
        check(m == 12'h3FC, "R11 open-all during busy ignored", int'(m), 12'h3FC);
        cmd_valid = 1'b1; cmd_op = 8'h55;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        check(!busy && !done, "R11 unknown opcode ignored", {busy, done}, 0);
        read_map(m);
        check(m == 12'h3FC, "R11 map unchanged after unknown opcode", int'(m), 12'h3FC);
    endtask

    task automatic t_empty_range();
        int n; bit e, d; logic [NB-1:0] m;
        wr_start(6); wr_end(4);
        run_cmd(8'h2A, n, e, d);
        check(d && !e && n == 1, "R13 reversed range ends after one cycle", n, 1);
        read_map(m);
        check(m == 12'h3FC, "R13 reversed range writes nothing", int'(m), 12'h3FC);
    endtask

    initial begin
        t_reset();
        t_range_regs();
        t_open_range();
        t_lock_range();
        t_tight_range();
        t_stop_on_tight();
        t_open_all();
        t_overrun();
        t_ignore();
        t_empty_range();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule